// File: doc/BRIEF.md
# Flash Row Erase and Program Controller

This block lets a processor erase and program an on-chip flash array one 64-byte row at a time. Software addresses a small set of byte-wide registers: a control register, a key register, and three bytes of a 22-bit table pointer. Bits 21 to 6 of the pointer choose the row. Bits 5 to 0 choose a slot in a 64-entry holding buffer. The holding buffer is filled through a valid/ready byte stream of table writes. Each table write touches only the buffer, never the array.

A row operation starts only when the key register has just received the byte 55h and then the byte AAh, and a control write with the start bit set follows. While the operation runs, `cpu_stall` holds the processor. An internal timer ends the operation after `PROG_CYCLES` clock cycles. When the timer ends, the array is updated in a single step: an erase fills the row with FFh, and a program copies the holding buffer into the row.

Table-write stream rules: a byte is taken on any clock edge where `tw_valid` and `tw_ready` are both high. `tw_ready` is low for the whole of a row operation. A producer must hold `tw_valid` and `tw_data` until the byte is taken.

Top module: `flash_row_ctrl`

## Requirements
- R1: After reset, the control register reads 00h, `cpu_stall` is 0, `tw_ready` is 1, and every array byte reads FFh.
- R2: The key register (select 1) unlocks when it receives AAh directly after 55h. Any key write other than 55h or the awaited AAh returns the sequence to idle. A 55h write always arms the first step. A start without the unlock does nothing.
- R3: Any control write with the start bit set consumes the unlock, even if the start does not launch.
- R4: A start launches only if the same control write (select 0) has all of the following: start (bit 0) = 1, write-enable (bit 1) = 1, program-memory select (bit 4) = 1, and config select (bit 3) = 0. Erase select is bit 2, where 1 means erase and 0 means program.
- R5: An erase sets all 64 bytes of the row chosen by pointer bits 21:6 to FFh. Pointer bits 5:0 are ignored, and no other row changes.
- R6: An accepted table write stores its byte in holding slot pointer[5:0]. It then increments pointer[5:0] modulo 64, leaves pointer[21:6] unchanged, and leaves the array unchanged.
- R7: A program copies all 64 holding slots into the chosen row. Afterwards every holding slot is reset to FFh.
- R8: `cpu_stall` is high for exactly `PROG_CYCLES` cycles, starting with the cycle after the start write. The control start bit reads 1 during that time and 0 afterwards.
- R9: During an operation, `tw_ready` is 0 and all register writes (pointer, key and control) are ignored.
- R10: The pointer reads back through select 2 (bits 7:0), select 3 (bits 15:8) and select 4 (bits 21:16, upper two bits read 0).
- R11: `fr_data` shows the array byte at `fr_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 3 | Register select: 0 control, 1 key, 2/3/4 pointer bytes |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Read data of the selected register |
| tw_valid | input | 1 | Table-write byte valid |
| tw_ready | output | 1 | Table-write byte accepted when high |
| tw_data | input | 8 | Table-write byte |
| fr_addr | input | ADDR_W | Array read address (row, byte) |
| fr_data | output | 8 | Array read data |
| cpu_stall | output | 1 | Processor stall during a row operation |

## Verification
The hardest case to reach is a key sequence that is accepted but then used up by a start that does not launch. Seen from outside, this looks the same as a start that was never unlocked. The bench therefore follows each rejected start with a second start that sends no new key. That second start must also leave `cpu_stall` low and the array unchanged. The bench also writes a full unlock sequence and pointer bytes while an operation is busy, and then shows that none of them took effect once the stall ends.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int unsigned SLOT_W    = 6;
  localparam int unsigned ROW_BYTES = 1 << SLOT_W;
  localparam int unsigned PTR_W     = 22;
  localparam logic [7:0]  KEY_FIRST  = 8'h55;
  localparam logic [7:0]  KEY_SECOND = 8'hAA;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_KEY     = 3'd1,
    SEL_PTR_LO  = 3'd2,
    SEL_PTR_MID = 3'd3,
    SEL_PTR_HI  = 3'd4
  } csr_sel_e;

  typedef struct packed {
    logic mem_sel;   // bit 4
    logic cfg_sel;   // bit 3
    logic erase_sel; // bit 2
    logic wr_en;     // bit 1
    logic start;     // bit 0
  } ctrl_t;
endpackage

// File: rtl/flash_key_unlock.sv
module flash_key_unlock
  import flash_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_val,
  input  logic       consume,
  output logic       unlocked
);
  typedef enum logic [1:0] {K_IDLE, K_ARMED, K_OPEN} key_st_e;
  key_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= K_IDLE;
    end else if (consume) begin
      st_q <= K_IDLE;
    end else if (key_we) begin
      if (key_val == KEY_FIRST)
        st_q <= K_ARMED;
      else if (st_q == K_ARMED && key_val == KEY_SECOND)
        st_q <= K_OPEN;
      else
        st_q <= K_IDLE;
    end
  end

  assign unlocked = (st_q == K_OPEN);

  assert_unlock_needs_second_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_we && key_val == KEY_SECOND));

  assert_start_consumes_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !unlocked);
endmodule

// File: rtl/flash_row_timer.sv
module flash_row_timer #(
  parameter int unsigned PROG_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (launch && !busy) begin
      busy  <= 1'b1;
      cnt_q <= LAST;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy && (cnt_q == '0);

  assert_done_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_count_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q <= LAST);

  assert_no_relaunch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
endmodule

// File: rtl/flash_latch_buf.sv
module flash_latch_buf
  import flash_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SLOT_W-1:0]              wr_idx,
  input  logic [7:0]                     wr_data,
  input  logic                           clear,
  output logic [ROW_BYTES-1:0][7:0]      lat_q
);
  for (genvar s = 0; s < ROW_BYTES; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        lat_q[s] <= 8'hFF;
      else if (wr_en && wr_idx == SLOT_W'(s))
        lat_q[s] <= wr_data;
    end
  end

  assert_clear_blanks_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lat_q[0] == 8'hFF) && (lat_q[ROW_BYTES-1] == 8'hFF));
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_pkg::*;
#(
  parameter int unsigned ROWS = 8,
  localparam int unsigned ROW_BITS = $clog2(ROWS),
  localparam int unsigned ADDR_W = ROW_BITS + SLOT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic                      erase,
  input  logic [ROW_BITS-1:0]       row_sel,
  input  logic [ROW_BYTES-1:0][7:0] lat,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [7:0]                rd_data
);
  logic [ROWS-1:0][ROW_BYTES-1:0][7:0] mem;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[r] <= '1;
      else if (commit && row_sel == ROW_BITS'(r))
        mem[r] <= erase ? '1 : lat;
    end
  end

  assign rd_data = mem[rd_addr[ADDR_W-1:SLOT_W]][rd_addr[SLOT_W-1:0]];

  assert_erase_blanks_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && erase) |=> mem[$past(row_sel)] == '1);
endmodule

// File: rtl/flash_row_ctrl.sv
module flash_row_ctrl
  import flash_pkg::*;
#(
  parameter int unsigned ROWS        = 8,
  parameter int unsigned PROG_CYCLES = 250000,
  localparam int unsigned ROW_BITS   = $clog2(ROWS),
  localparam int unsigned ADDR_W     = ROW_BITS + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [2:0]        csr_sel,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              tw_valid,
  output logic              tw_ready,
  input  logic [7:0]        tw_data,
  input  logic [ADDR_W-1:0] fr_addr,
  output logic [7:0]        fr_data,
  output logic              cpu_stall
);
  ctrl_t                    ctrl_q;
  ctrl_t                    ctrl_wr;
  logic [PTR_W-1:0]         ptr_q;
  logic                     op_erase_q;
  logic                     busy, done, unlocked;
  logic                     we_ok, wr_ctrl, start_req, start_fire, tw_fire;
  logic [ROW_BYTES-1:0][7:0] lat;
  logic                     unused_hi;

  assign ctrl_wr   = ctrl_t'(csr_wdata[4:0]);
  assign unused_hi = ^csr_wdata[7:5];
  assign we_ok     = csr_we && !busy;
  assign wr_ctrl   = we_ok && (csr_sel_e'(csr_sel) == SEL_CTRL);
  assign start_req = wr_ctrl && ctrl_wr.start;
  assign start_fire = start_req && unlocked && ctrl_wr.wr_en
                   && ctrl_wr.mem_sel && !ctrl_wr.cfg_sel;
  assign tw_ready  = !busy;
  assign tw_fire   = tw_valid && tw_ready;
  assign cpu_stall = busy;

  flash_key_unlock u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (we_ok && (csr_sel_e'(csr_sel) == SEL_KEY)),
    .key_val  (csr_wdata),
    .consume  (start_req),
    .unlocked (unlocked)
  );

  flash_row_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (start_fire),
    .busy   (busy),
    .done   (done)
  );

  flash_latch_buf u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tw_fire),
    .wr_idx  (ptr_q[SLOT_W-1:0]),
    .wr_data (tw_data),
    .clear   (done && !op_erase_q),
    .lat_q   (lat)
  );

  flash_array #(.ROWS(ROWS)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (done),
    .erase   (op_erase_q),
    .row_sel (ptr_q[SLOT_W +: ROW_BITS]),
    .lat     (lat),
    .rd_addr (fr_addr),
    .rd_data (fr_data)
  );

  // Control register and operation kind
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      op_erase_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q       <= ctrl_wr;
        ctrl_q.start <= start_fire;
      end
      if (start_fire) op_erase_q <= ctrl_wr.erase_sel;
      if (done)       ctrl_q.start <= 1'b0;
    end
  end

  // Table pointer: table writes step the slot index, register writes take precedence
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      if (tw_fire)
        ptr_q[SLOT_W-1:0] <= ptr_q[SLOT_W-1:0] + 1'b1;
      if (we_ok) begin
        unique case (csr_sel_e'(csr_sel))
          SEL_PTR_LO:  ptr_q[7:0]   <= csr_wdata;
          SEL_PTR_MID: ptr_q[15:8]  <= csr_wdata;
          SEL_PTR_HI:  ptr_q[21:16] <= csr_wdata[5:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (csr_sel_e'(csr_sel))
      SEL_CTRL:    csr_rdata = {3'b000, ctrl_q};
      SEL_PTR_LO:  csr_rdata = ptr_q[7:0];
      SEL_PTR_MID: csr_rdata = ptr_q[15:8];
      SEL_PTR_HI:  csr_rdata = {2'b00, ptr_q[21:16]};
      default:     csr_rdata = 8'h00;
    endcase
  end

  assert_stall_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> cpu_stall);

  assert_start_bit_tracks_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.start == busy);

  assert_ptr_frozen_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ptr_q));

  assert_launch_needs_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(unlocked));
endmodule

// File: tb/flash_row_ctrl_tb.sv
`timescale 1ns/1ps
module flash_row_ctrl_tb;
  localparam int ROWS = 4;
  localparam int PC   = 8;
  localparam int AW   = 8;
  localparam int NB   = ROWS * 64;

  logic clk = 0, rst_n = 0;
  logic csr_we = 0; logic [2:0] csr_sel = 0; logic [7:0] csr_wdata = 0;
  logic [7:0] csr_rdata;
  logic tw_valid = 0, tw_ready; logic [7:0] tw_data = 0;
  logic [AW-1:0] fr_addr = 0; logic [7:0] fr_data;
  logic cpu_stall;

  int n_run = 0, n_fail = 0;
  logic [7:0] model [NB];
  bit finished = 0;

  always #4 clk = ~clk;

  flash_row_ctrl #(.ROWS(ROWS), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .tw_valid(tw_valid),
    .tw_ready(tw_ready), .tw_data(tw_data), .fr_addr(fr_addr),
    .fr_data(fr_data), .cpu_stall(cpu_stall));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); csr_we = 1; csr_sel = s; csr_wdata = d;
    @(negedge clk); csr_we = 0; csr_sel = 0;
  endtask

  task automatic csr_rd(input logic [2:0] s, output logic [7:0] d);
    csr_sel = s; #1; d = csr_rdata; csr_sel = 0;
  endtask

  task automatic tw(input logic [7:0] d);
    @(negedge clk); tw_valid = 1; tw_data = d;
    @(negedge clk); tw_valid = 0;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    csr_wr(2, p[7:0]); csr_wr(3, p[15:8]); csr_wr(4, {2'b00, p[21:16]});
  endtask

  task automatic unlock();
    csr_wr(1, 8'h55); csr_wr(1, 8'hAA);
  endtask

  // Issues a control write and returns the number of stalled cycles
  task automatic go(input logic [7:0] c, output int n);
    csr_wr(0, c);
    n = 0;
    while (cpu_stall && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic cmp_all(input string req);
    int bad = 0; int first = -1; logic [7:0] got = 0;
    for (int a = 0; a < NB; a++) begin
      fr_addr = AW'(a); #1;
      if (fr_data !== model[a]) begin
        if (first < 0) begin first = a; got = fr_data; end
        bad++;
      end
    end
    if (first < 0) chk(req, 0, 0);
    else chk({req, " byte mismatch"}, got, model[first]);
  endtask

  initial begin : watchdog
    #(8ns * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r; int n;
    for (int a = 0; a < NB; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    csr_rd(0, r); chk("R1 ctrl", r, 0);
    chk("R1 stall", cpu_stall, 0);
    chk("R1 tw_ready", tw_ready, 1);
    cmp_all("R1 array blank");

    // R6 R7 R8 R11: program every row with an arithmetic pattern
    for (int row = 0; row < ROWS; row++) begin
      set_ptr(22'(row << 6));
      for (int i = 0; i < 64; i++) tw(8'((row * 53 + i * 7 + 3)));
      csr_rd(2, r); chk("R6 slot index wraps", r, (row << 6) & 8'hFF);
      fr_addr = AW'(row << 6); #1;
      chk("R6 array untouched by table writes", fr_data, model[row << 6]);
      unlock();
      csr_wr(0, 8'h13);
      csr_rd(0, r); chk("R8 start bit while busy", r, 8'h13);
      n = 1;
      while (cpu_stall && n < 100) begin @(negedge clk); if (cpu_stall) n++; end
      chk("R8 stall length", n, PC);
      csr_rd(0, r); chk("R8 start bit cleared", r, 8'h12);
      for (int i = 0; i < 64; i++) model[row * 64 + i] = 8'((row * 53 + i * 7 + 3));
      cmp_all("R7 program row");
    end

    // R7 latches reset to FF after programming: reprogram row 1 with no loads
    set_ptr(22'h000040);
    unlock(); go(8'h13, n); chk("R7 reprogram stall", n, PC);
    for (int i = 0; i < 64; i++) model[64 + i] = 8'hFF;
    cmp_all("R7 latches blank after program");

    // R5 erase with nonzero low pointer bits and high bits set
    set_ptr(22'h3F00AA);  // row field bits 7:6 = 2, low bits 0x2A
    unlock(); go(8'h17, n); chk("R5 erase stall", n, PC);
    for (int i = 0; i < 64; i++) model[128 + i] = 8'hFF;
    cmp_all("R5 erase row only");

    // R2 broken key sequences
    set_ptr(22'h0000C0);
    csr_wr(1, 8'h55); csr_wr(1, 8'h12); csr_wr(1, 8'hAA);
    go(8'h17, n); chk("R2 55,12,AA rejected", n, 0);
    csr_wr(1, 8'hAA);
    go(8'h17, n); chk("R2 AA alone rejected", n, 0);
    cmp_all("R2 array unchanged");
    csr_wr(1, 8'h55); csr_wr(1, 8'h55); csr_wr(1, 8'hAA);
    go(8'h17, n); chk("R2 55,55,AA accepted", n, PC);
    for (int i = 0; i < 64; i++) model[192 + i] = 8'hFF;
    cmp_all("R2 erase after rearm");

    // R3 unlock consumed by a failed start (write-enable clear)
    set_ptr(22'h000000);
    unlock(); go(8'h15, n); chk("R3 no wren no launch", n, 0);
    go(8'h17, n); chk("R3 unlock consumed", n, 0);
    cmp_all("R3 array unchanged");

    // R4 qualifying bits
    unlock(); go(8'h1F, n); chk("R4 cfg select blocks", n, 0);
    unlock(); go(8'h07, n); chk("R4 mem select required", n, 0);
    cmp_all("R4 array unchanged");

    // R9 writes ignored while busy
    set_ptr(22'h000000);
    unlock();
    csr_wr(0, 8'h17);
    chk("R9 tw_ready low busy", tw_ready, 0);
    csr_wr(2, 8'h05); csr_wr(1, 8'h55); csr_wr(1, 8'hAA);
    while (cpu_stall) @(negedge clk);
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    csr_rd(2, r); chk("R9 pointer write ignored", r, 0);
    go(8'h17, n); chk("R9 key writes ignored", n, 0);
    cmp_all("R9 array state");

    // R10 pointer readback
    set_ptr(22'h3FA5C3);
    csr_rd(2, r); chk("R10 ptr lo", r, 8'hC3);
    csr_rd(3, r); chk("R10 ptr mid", r, 8'hA5);
    csr_wr(4, 8'hFF);
    csr_rd(4, r); chk("R10 ptr hi masked", r, 8'h3F);

    // R6 slot wrap keeps row bits
    set_ptr(22'h00007E);
    tw(8'h11); tw(8'h22);
    csr_rd(2, r); chk("R6 wrap keeps row field", r, 8'h40);
    cmp_all("R6 array untouched");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule